// File: doc/BRIEF.md
# Interrupt Service Request Node

This block is one interrupt request node. It keeps a single pending-request flag and an enable bit behind a one-word control register. Peripheral hardware raises or drops the flag with event strobes. The service provider clears it with an acknowledge. Software cannot write the flag bit directly. It changes the flag only through two write-one command bits: a set command and a clear command. These bits are not stored and always read back as zero.

The enable bit does not decide whether the flag can be set. It decides only whether a pending flag is passed to the interrupt arbiter, through a registered request output. With enable low, software polls the flag and clears it itself. The bus raises a lock input while it performs a read-modify-write on the register. Hardware events that arrive while the lock is high are thrown away, so the software result is what remains.

Top module: `irq_srn_node`

## Requirements
- R1: A synchronous active-low reset clears the enable bit, the pending flag and the request output, and the read word becomes all zeros, even if hardware events are asserted during reset.
- R2: A write with bit 2 (set command) = 1 and bit 3 (clear command) = 0 sets the flag. A write with bit 3 = 1 and bit 2 = 0 clears the flag. The flag reads back on bit 1 after the clock edge that takes the write.
- R3: A write with both bit 2 and bit 3 at 1 leaves the flag at its previous value.
- R4: Writing 0 to bit 2 and bit 3 leaves the flag unchanged. Read bits 2 and 3, and every bit above bit 1, always read 0.
- R5: The value written to bit 1 is ignored. Writing 1 there does not set the flag, and writing 0 there does not clear it.
- R6: Every write loads the enable bit from bit 0. The enable value never blocks the hardware set or the software set command.
- R7: The request output equals flag AND enable as they stood before the previous clock edge. It follows a change one clock after the register changes.
- R8: An acknowledge pulse clears the flag, and so does a hardware clear pulse.
- R9: With the lock low and no software command, a hardware set in the same cycle as a hardware clear or an acknowledge leaves the flag at 1.
- R10: While the lock is high, hardware set, hardware clear and acknowledge have no effect. They are not applied later.
- R11: A software set or clear command in the same cycle as a hardware event decides the flag, whether or not the lock is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_wdata | input | DATA_W | Write data: bit 0 enable, bit 1 ignored, bit 2 set command, bit 3 clear command |
| reg_rdata | output | DATA_W | Read data: bit 0 enable, bit 1 pending flag, all other bits 0 |
| rmw_lock | input | 1 | High while the bus holds a read-modify-write on the register |
| hw_set | input | 1 | Hardware event that sets the flag |
| hw_clr | input | 1 | Hardware event that clears the flag |
| svc_ack | input | 1 | Acknowledge from the service provider, clears the flag |
| arb_req | output | 1 | Registered request to the interrupt arbiter |

## Verification
The assertions check on every cycle that:
- command bits always read as zero;
- a lone set or clear command takes effect;
- a both-ones command holds the flag;
- a lock without a software command freezes the flag;
- a hardware set beats a same-cycle clear;
- the request output follows flag AND enable one cycle later.

Other properties depend on sequences of cycles, and only the bench's scenarios can show them:
- a locked event is truly dropped and does not reappear in a later cycle;
- a poll-and-clear sequence works with the enable low;
- a value written to bit 1 is ignored.

The bench's reference model compares the read word and the request on every clock, through directed and random traffic.

// File: rtl/srn_pkg.sv
// Package: shared bit positions and the software flag action type for the
// interrupt service request node. Assumes a register word of at least 4 bits.
package srn_pkg;

    localparam int unsigned POS_EN   = 0;  // enable, read/write
    localparam int unsigned POS_FLAG = 1;  // pending flag, read-only
    localparam int unsigned POS_SET  = 2;  // set command, write-one
    localparam int unsigned POS_CLR  = 3;  // clear command, write-one

    typedef enum logic [1:0] {
        SW_NONE = 2'd0,
        SW_SET  = 2'd1,
        SW_CLR  = 2'd2
    } sw_act_e;

    typedef struct packed {
        logic set;
        logic clr;
        logic ack;
    } hw_evt_t;

endpackage

// File: rtl/srn_regif.sv
// Register interface: holds the enable bit, decodes the write-one commands
// into a single flag action, and assembles the read word.
// Assumes one-cycle write strobes and DATA_W > POS_CLR.
module srn_regif
    import srn_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              flag,
    output logic              en_q,
    output sw_act_e           sw_act,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned MSB = DATA_W - 1;

    logic unused_wbits;
    logic cmd_set;
    logic cmd_clr;

    // Ignored write bits: only enable and the two commands are consumed.
    assign unused_wbits = ^{wdata[MSB:POS_CLR+1], wdata[POS_FLAG]};
    assign cmd_set      = wr & wdata[POS_SET];
    assign cmd_clr      = wr & wdata[POS_CLR];

    // Enable register: loaded from bit 0 on every write.
    always_ff @(posedge clk) begin
        if (!rst_n)  en_q <= 1'b0;
        else if (wr) en_q <= wdata[POS_EN];
    end

    // Command decode: a set and a clear in the same write cancel out.
    always_comb begin
        sw_act = SW_NONE;
        if (cmd_set && !cmd_clr)      sw_act = SW_SET;
        else if (cmd_clr && !cmd_set) sw_act = SW_CLR;
    end

    // Read word: enable and flag in fixed places, commands and spares read 0.
    generate
        for (genvar b = 0; b < DATA_W; b++) begin : g_rd
            if (b == POS_EN)        begin : g_en   assign rdata[b] = en_q; end
            else if (b == POS_FLAG) begin : g_flag assign rdata[b] = flag; end
            else                    begin : g_zero assign rdata[b] = 1'b0; end
        end
    endgenerate

    assert_cmd_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[POS_SET] == 1'b0) && (rdata[POS_CLR] == 1'b0));

    assert_en_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (en_q == $past(wdata[POS_EN])));

endmodule

// File: rtl/srn_flag.sv
// Pending flag: applies software actions ahead of hardware events. Drops
// hardware events while the bus lock is high. Within hardware, a set beats
// a clear or an acknowledge.
// Assumes the software action is already decoded (cancelled commands = none).
module srn_flag
    import srn_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  sw_act_e sw_act,
    input  logic    lock,
    input  hw_evt_t hw,
    output logic    flag_q
);

    logic hw_drop;
    logic hw_clear_any;

    // Hardware qualification: the lock discards events outright.
    assign hw_drop      = lock;
    assign hw_clear_any = hw.clr | hw.ack;

    // Flag register update in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            unique case (sw_act)
                SW_SET:  flag_q <= 1'b1;
                SW_CLR:  flag_q <= 1'b0;
                default: begin
                    if (!hw_drop) begin
                        if (hw.set)           flag_q <= 1'b1;
                        else if (hw_clear_any) flag_q <= 1'b0;
                    end
                end
            endcase
        end
    end

    assert_sw_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_act == SW_SET) |=> flag_q);

    assert_sw_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_act == SW_CLR) |=> !flag_q);

    assert_lock_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && sw_act == SW_NONE) |=> $stable(flag_q));

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock && sw_act == SW_NONE && hw.set) |=> flag_q);

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock && sw_act == SW_NONE && !hw.set && hw.ack) |=> !flag_q);

endmodule

// File: rtl/srn_fwd.sv
// Request forwarding: registers flag AND enable toward the arbiter, so the
// output moves one clock after the register state. Assumes nothing else.
module srn_fwd (
    input  logic clk,
    input  logic rst_n,
    input  logic flag,
    input  logic en,
    output logic req_q
);

    // Output stage: forward only while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= flag & en;
    end

    assert_req_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && en) |=> req_q);

    assert_req_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag && en) |=> !req_q);

endmodule

// File: rtl/irq_srn_node.sv
// Top: one interrupt service request node. It joins the register
// interface, the pending flag and the registered arbiter request.
// Assumes the bus drives reg_wr for one cycle per write, and raises
// rmw_lock for the whole read-modify-write window.
module irq_srn_node
    import srn_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              rmw_lock,
    input  logic              hw_set,
    input  logic              hw_clr,
    input  logic              svc_ack,
    output logic              arb_req
);

    sw_act_e sw_act;
    hw_evt_t hw;
    logic    en_q;
    logic    flag_q;

    // Bundle the hardware strobes for the flag stage.
    assign hw = '{set: hw_set, clr: hw_clr, ack: svc_ack};

    srn_regif #(.DATA_W(DATA_W)) u_regif (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .wdata  (reg_wdata),
        .flag   (flag_q),
        .en_q   (en_q),
        .sw_act (sw_act),
        .rdata  (reg_rdata)
    );

    srn_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_act (sw_act),
        .lock   (rmw_lock),
        .hw     (hw),
        .flag_q (flag_q)
    );

    srn_fwd u_fwd (
        .clk   (clk),
        .rst_n (rst_n),
        .flag  (flag_q),
        .en    (en_q),
        .req_q (arb_req)
    );

    assert_both_cmds_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[POS_SET] && reg_wdata[POS_CLR] && rmw_lock)
        |=> $stable(reg_rdata[POS_FLAG]));

    assert_sw_beats_hw_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[POS_CLR] && !reg_wdata[POS_SET] && hw_set)
        |=> !reg_rdata[POS_FLAG]);

endmodule

// File: tb/sim_irq_srn_node.sv
module sim_irq_srn_node;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic         rmw_lock = 1'b0;
    logic         hw_set = 1'b0;
    logic         hw_clr = 1'b0;
    logic         svc_ack = 1'b0;
    logic         arb_req;

    integer n_checks = 0;
    integer n_fail = 0;
    bit     m_flag = 0, m_en = 0, m_req = 0;

    always #10 clk = ~clk;

    irq_srn_node #(.DATA_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .rmw_lock(rmw_lock), .hw_set(hw_set),
        .hw_clr(hw_clr), .svc_ack(svc_ack), .arb_req(arb_req)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive at negedge, update the model, compare at next negedge.
    task automatic cyc(input bit w, input logic [3:0] d, input bit hs, input bit hc,
                       input bit ak, input bit lk, input string tag);
        bit nf, ne, nr;
        reg_wr = w; reg_wdata = {{(W-4){1'b1}}, d};
        hw_set = hs; hw_clr = hc; svc_ack = ak; rmw_lock = lk;
        nr = m_flag & m_en;
        ne = w ? d[0] : m_en;
        nf = m_flag;
        if (!rst_n) begin
            nf = 0; ne = 0; nr = 0;
        end else if (w && d[2] && !d[3]) nf = 1;
        else if (w && d[3] && !d[2])     nf = 0;
        else if (!lk) begin
            if (hs)            nf = 1;
            else if (hc || ak) nf = 0;
        end
        @(posedge clk);
        @(negedge clk);
        m_flag = nf; m_en = ne; m_req = nr;
        check({tag, " rdata"}, reg_rdata, {{(W-2){1'b0}}, m_flag, m_en});
        check({tag, " req"}, {{(W-1){1'b0}}, arb_req}, {{(W-1){1'b0}}, m_req});
        reg_wr = 0; hw_set = 0; hw_clr = 0; svc_ack = 0; rmw_lock = 0;
    endtask

    task automatic idle(input string tag);
        cyc(0, 4'h0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset dominates hardware events
        cyc(0, 4'h0, 1, 0, 0, 0, "R1");
        cyc(1, 4'h5, 1, 0, 0, 0, "R1");
        rst_n = 1;
        // R6: enable loads from bit 0
        cyc(1, 4'h1, 0, 0, 0, 0, "R6");
        idle("R7");
        // R2: set command, then R7 request a clock later
        cyc(1, 4'h5, 0, 0, 0, 0, "R2");
        idle("R7");
        cyc(1, 4'h9, 0, 0, 0, 0, "R2");
        idle("R7");
        // R3: both commands hold, from 0 and from 1
        cyc(1, 4'hD, 0, 0, 0, 0, "R3");
        cyc(1, 4'h5, 0, 0, 0, 0, "R2");
        cyc(1, 4'hD, 0, 0, 0, 0, "R3");
        cyc(1, 4'hD, 0, 0, 0, 1, "R3");
        // R5: bit 1 written is ignored
        cyc(1, 4'h1, 0, 0, 0, 0, "R5");
        cyc(1, 4'h9, 0, 0, 0, 0, "R2");
        cyc(1, 4'h3, 0, 0, 0, 0, "R5");
        // R4: zeros in command bits do nothing
        cyc(1, 4'h1, 0, 0, 0, 0, "R4");
        // R6: enable low, hw set and sw set still set the flag; poll and clear
        cyc(1, 4'h0, 0, 0, 0, 0, "R6");
        cyc(0, 4'h0, 1, 0, 0, 0, "R6");
        idle("R7");
        cyc(1, 4'h8, 0, 0, 0, 0, "R6");
        cyc(1, 4'h4, 0, 0, 0, 0, "R6");
        idle("R7");
        cyc(1, 4'h9, 0, 0, 0, 0, "R6");
        // R8: acknowledge and hardware clear
        cyc(0, 4'h0, 1, 0, 0, 0, "R8");
        cyc(0, 4'h0, 0, 0, 1, 0, "R8");
        cyc(0, 4'h0, 1, 0, 0, 0, "R8");
        cyc(0, 4'h0, 0, 1, 0, 0, "R8");
        // R9: set beats clear and ack
        cyc(0, 4'h0, 1, 1, 0, 0, "R9");
        cyc(0, 4'h0, 0, 1, 0, 0, "R8");
        cyc(0, 4'h0, 1, 0, 1, 0, "R9");
        // R10: locked events dropped and not deferred
        cyc(0, 4'h0, 0, 1, 1, 1, "R10");
        idle("R10");
        cyc(1, 4'h9, 0, 0, 0, 0, "R2");
        cyc(0, 4'h0, 1, 0, 0, 1, "R10");
        idle("R10");
        // R11: software commands beat hardware, with and without lock
        cyc(1, 4'h9, 1, 0, 0, 1, "R11");
        cyc(1, 4'h5, 0, 1, 1, 1, "R11");
        cyc(1, 4'h9, 1, 0, 0, 0, "R11");
        cyc(1, 4'h5, 0, 0, 1, 0, "R11");
        // Random traffic checked against the model
        for (int i = 0; i < 400; i++) begin
            int unsigned r;
            r = $urandom;
            cyc(r[0] & r[1], r[5:2], r[6], r[7] & r[8], r[9] & r[10], r[11] & r[12], "R7");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule